// File: doc/BRIEF.md
# Vector load/store address sequencer

This block turns one vectorised load or store instruction into a series of memory requests, one per active element. Once it accepts the instruction's upper fields, its width field, the base register number with its vector flag, the offset-register vector flag, the destination vector flag, a vector length and a predicate mask, it walks the loop index from zero upward. For each index it reads a base register and an offset register through two combinational register-read ports. It then forms a 64-bit byte address and presents it on a valid/ready request port together with the element index.

The two top instruction bits pick how the per-element offset is formed. In the first mode the offset is the element size times the index. In the second mode it is the element size times the index times an offset register. In the third mode the offset is simply the offset register's value; when that register is vectorised, each element uses a different register, which gives an indexed access. The immediate is rebuilt from different instruction bits depending on the mode. A scalar destination changes the loop into a search that ends at the first active element. If zeroing is also set, that first active element raises an exception flag and no request is made.

Top module: `vls_seq`

## Requirements
- R1: The element size in bytes is 1 shifted left by width[1:0], so codes 0, 1, 2 and 3 give 1, 2, 4 and 8 bytes; width[2] has no effect on addresses.
- R2: With insn_hi[11]=0 and insn_hi[10]=0 (element stride), the address of element i is base + esize*i + imm.
- R3: With insn_hi[11]=0 and insn_hi[10]=1 (constant stride), the address of element i is base + esize*i*ofs + imm. Here ofs is read from the register numbered insn_hi[9:5].
- R4: With insn_hi[11]=1 (indexed), the address of element i is base + ofs + imm. The offset register is insn_hi[9:5] when rs2_vec is 0, and insn_hi[9:5]+i modulo 32 when rs2_vec is 1; the same choice applies in the constant-stride mode.
- R5: The base register is rs1+i modulo 32 when rs1_vec is 1, and rs1 for every element when rs1_vec is 0.
- R6: The immediate is sign-extended from insn_hi[9:0] in element-stride mode, from insn_hi[3:0] in constant-stride mode, and from {insn_hi[10], insn_hi[3:0]} in indexed mode.
- R7: An element whose predicate bit is 0 takes one cycle and makes no request.
- R8: When rd_vec is 0 and pred_zero is 0, the loop ends after the first accepted request.
- R9: When rd_vec is 0 and pred_zero is 1, the first element whose predicate bit is 1 raises exc for one cycle instead of a request, and the loop then ends. With rd_vec at 1, pred_zero has no effect.
- R10: A vector length of 0 gives done in the cycle after start, with no request and no exception. A length above MAXVL is treated as MAXVL.
- R11: While req_valid is high and req_ready is low, req_addr and req_idx hold. Each accepted request advances the loop by one element.
- R12: busy is high while elements are being stepped. done is a one-cycle pulse in the cycle after the loop ends, and busy is low while done is high. start is accepted only when busy is low.
- R13: Address arithmetic wraps modulo 2^64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Accept a new instruction when idle |
| insn_hi | input | 12 | Instruction bits 31:20 |
| width | input | 3 | Element width code |
| rs1 | input | 5 | Base register number |
| rs1_vec | input | 1 | Base register is vectorised |
| rs2_vec | input | 1 | Offset register is vectorised |
| rd_vec | input | 1 | Destination is vectorised |
| vl | input | 5 | Vector length |
| pred | input | 16 | Predicate mask, bit i for element i |
| pred_zero | input | 1 | Predicate zeroing enabled |
| base_raddr | output | 5 | Base register read address |
| base_rdata | input | 64 | Base register read data |
| ofs_raddr | output | 5 | Offset register read address |
| ofs_rdata | input | 64 | Offset register read data |
| req_valid | output | 1 | Memory request valid |
| req_ready | input | 1 | Memory port accepts the request |
| req_addr | output | 64 | Request byte address |
| req_idx | output | 5 | Element index of the request |
| busy | output | 1 | Loop in progress |
| done | output | 1 | One-cycle completion pulse |
| exc | output | 1 | Zeroing exception on a scalar destination |

## Verification
The bench aims at the predicate holes in indexed mode. A sequencer that ignored the mask would issue requests for the masked elements, and one that stalled on them would delay the later indices. It also covers the scalar-destination search, both with and without zeroing. Getting this wrong would show up as extra requests after the first active element, or as a request where the exception belongs. Further targets are negative immediates in each mode, base values that push the address past 2^64, a zero vector length that must finish at once, and requests held against a low ready, which a faulty design would let advance or change.

// File: rtl/vls_pkg.sv
package vls_pkg;

    localparam int XLEN = 64;
    localparam int RW   = 5;

    typedef enum logic [1:0] {
        AM_ELEM  = 2'b00,
        AM_CSTR  = 2'b01,
        AM_INDEX = 2'b10
    } amode_t;

    typedef struct packed {
        amode_t            mode;
        logic [XLEN-1:0]   imm;
        logic [RW-1:0]     rs2;
        logic [1:0]        esz_lg;
    } xcfg_t;

    function automatic amode_t mode_of(input logic [11:0] hi);
        if (hi[11])      return AM_INDEX;
        else if (hi[10]) return AM_CSTR;
        else             return AM_ELEM;
    endfunction

    function automatic logic [XLEN-1:0] imm_of(input logic [11:0] hi);
        case (mode_of(hi))
            AM_ELEM: return {{(XLEN-10){hi[9]}}, hi[9:0]};
            AM_CSTR: return {{(XLEN-4){hi[3]}}, hi[3:0]};
            default: return {{(XLEN-5){hi[10]}}, hi[10], hi[3:0]};
        endcase
    endfunction

endpackage

// File: rtl/vls_decode.sv
module vls_decode
    import vls_pkg::*;
(
    input  logic [11:0] insn_hi,
    input  logic [2:0]  width,
    output xcfg_t       cfg
);
    always_comb begin
        cfg.mode   = mode_of(insn_hi);
        cfg.imm    = imm_of(insn_hi);
        cfg.rs2    = insn_hi[9:5];
        cfg.esz_lg = width[1:0];
    end
endmodule

// File: rtl/vls_addr_gen.sv
module vls_addr_gen
    import vls_pkg::*;
#(
    parameter int VW = 5
) (
    input  xcfg_t            cfg,
    input  logic [RW-1:0]    rs1,
    input  logic             rs1_vec,
    input  logic             rs2_vec,
    input  logic [VW-1:0]    idx,
    output logic [RW-1:0]    base_raddr,
    output logic [RW-1:0]    ofs_raddr,
    input  logic [XLEN-1:0]  base_rdata,
    input  logic [XLEN-1:0]  ofs_rdata,
    output logic [XLEN-1:0]  addr
);
    logic [XLEN-1:0] idx_x;
    logic [XLEN-1:0] offset;

    assign idx_x      = XLEN'(idx);
    assign base_raddr = rs1_vec ? RW'(rs1 + RW'(idx)) : rs1;
    assign ofs_raddr  = rs2_vec ? RW'(cfg.rs2 + RW'(idx)) : cfg.rs2;

    always_comb begin
        case (cfg.mode)
            AM_ELEM: offset = idx_x << cfg.esz_lg;
            AM_CSTR: offset = (ofs_rdata * idx_x) << cfg.esz_lg;
            default: offset = ofs_rdata;
        endcase
        addr = base_rdata + offset + cfg.imm;
    end
endmodule

// File: rtl/vls_ctrl.sv
module vls_ctrl #(
    parameter int MAXVL = 16,
    parameter int VW    = $clog2(MAXVL + 1),
    parameter int IW    = $clog2(MAXVL)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [VW-1:0]    vl,
    input  logic [MAXVL-1:0] pred,
    input  logic             pred_zero,
    input  logic             rd_vec,
    input  logic             req_ready,
    output logic             load,
    output logic [VW-1:0]    idx,
    output logic             busy,
    output logic             done,
    output logic             req_valid,
    output logic             exc
);
    typedef enum logic {ST_IDLE, ST_RUN} state_t;

    state_t           st;
    logic [VW-1:0]    vl_q;
    logic [MAXVL-1:0] pred_q;
    logic             zero_q;
    logic             vd_q;
    logic [VW-1:0]    vl_eff;
    logic             run, active, trap, step, last, finish;

    assign vl_eff    = (vl > VW'(MAXVL)) ? VW'(MAXVL) : vl;
    assign run       = (st == ST_RUN);
    assign busy      = run;
    assign load      = start && !run;
    assign active    = pred_q[idx[IW-1:0]];
    assign trap      = active && !vd_q && zero_q;
    assign req_valid = run && active && !trap;
    assign exc       = run && trap;
    assign step      = run && (!active || trap || req_ready);
    assign last      = (idx == VW'(vl_q - 1'b1));
    assign finish    = step && (last || (active && !vd_q));

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            idx    <= '0;
            vl_q   <= '0;
            pred_q <= '0;
            zero_q <= 1'b0;
            vd_q   <= 1'b1;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (load) begin
                idx    <= '0;
                vl_q   <= vl_eff;
                pred_q <= pred;
                zero_q <= pred_zero;
                vd_q   <= rd_vec;
                if (vl_eff == '0) done <= 1'b1;
                else              st   <= ST_RUN;
            end else if (step) begin
                if (finish) begin
                    st   <= ST_IDLE;
                    done <= 1'b1;
                end else begin
                    idx <= idx + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/vls_seq.sv
module vls_seq
    import vls_pkg::*;
#(
    parameter int MAXVL = 16,
    parameter int VW    = $clog2(MAXVL + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [11:0]      insn_hi,
    input  logic [2:0]       width,
    input  logic [4:0]       rs1,
    input  logic             rs1_vec,
    input  logic             rs2_vec,
    input  logic             rd_vec,
    input  logic [VW-1:0]    vl,
    input  logic [MAXVL-1:0] pred,
    input  logic             pred_zero,
    output logic [4:0]       base_raddr,
    input  logic [63:0]      base_rdata,
    output logic [4:0]       ofs_raddr,
    input  logic [63:0]      ofs_rdata,
    output logic             req_valid,
    input  logic             req_ready,
    output logic [63:0]      req_addr,
    output logic [VW-1:0]    req_idx,
    output logic             busy,
    output logic             done,
    output logic             exc
);
    xcfg_t         cfg_d, cfg_q;
    logic [RW-1:0] rs1_q;
    logic          rs1v_q, rs2v_q;
    logic          load;

    vls_decode u_dec (
        .insn_hi (insn_hi),
        .width   (width),
        .cfg     (cfg_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            rs1_q  <= '0;
            rs1v_q <= 1'b0;
            rs2v_q <= 1'b0;
        end else if (load) begin
            cfg_q  <= cfg_d;
            rs1_q  <= rs1;
            rs1v_q <= rs1_vec;
            rs2v_q <= rs2_vec;
        end
    end

    vls_ctrl #(.MAXVL(MAXVL), .VW(VW)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .vl        (vl),
        .pred      (pred),
        .pred_zero (pred_zero),
        .rd_vec    (rd_vec),
        .req_ready (req_ready),
        .load      (load),
        .idx       (req_idx),
        .busy      (busy),
        .done      (done),
        .req_valid (req_valid),
        .exc       (exc)
    );

    vls_addr_gen #(.VW(VW)) u_agen (
        .cfg        (cfg_q),
        .rs1        (rs1_q),
        .rs1_vec    (rs1v_q),
        .rs2_vec    (rs2v_q),
        .idx        (req_idx),
        .base_raddr (base_raddr),
        .ofs_raddr  (ofs_raddr),
        .base_rdata (base_rdata),
        .ofs_rdata  (ofs_rdata),
        .addr       (req_addr)
    );
endmodule

// File: rtl/vls_seq_chk.sv
module vls_seq_chk #(
    parameter int VW = 5
) (
    input logic          clk,
    input logic          rst,
    input logic          req_valid,
    input logic          req_ready,
    input logic [63:0]   req_addr,
    input logic [VW-1:0] req_idx,
    input logic          busy,
    input logic          done,
    input logic          exc
);
    assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_idx)));

    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_idle_R12: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    assert_req_busy_R12: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> busy);

    assert_exc_noreq_R9: assert property (@(posedge clk) disable iff (rst)
        exc |-> !req_valid);

    assert_exc_ends_R9: assert property (@(posedge clk) disable iff (rst)
        exc |=> done);
endmodule

bind vls_seq vls_seq_chk #(.VW(VW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .req_idx   (req_idx),
    .busy      (busy),
    .done      (done),
    .exc       (exc)
);

// File: tb/test_vls_seq.sv
`timescale 1ns/1ps
module test_vls_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [11:0] insn_hi = '0;
    logic [2:0]  width = '0;
    logic [4:0]  rs1 = '0;
    logic        rs1_vec = 1'b0, rs2_vec = 1'b0, rd_vec = 1'b1;
    logic [4:0]  vl = '0;
    logic [15:0] pred = '0;
    logic        pred_zero = 1'b0;
    logic [4:0]  base_raddr, ofs_raddr;
    logic [63:0] base_rdata, ofs_rdata;
    logic        req_valid, busy, done, exc;
    logic        req_ready = 1'b1;
    logic [63:0] req_addr;
    logic [4:0]  req_idx;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    function automatic logic [63:0] regval(input logic [4:0] r);
        return 64'hFFFF_FFFF_FFFF_FF00 + 64'(r) * 64'h40;
    endfunction

    assign base_rdata = regval(base_raddr);
    assign ofs_rdata  = regval(ofs_raddr);

    vls_seq i_vls_seq (
        .clk(clk), .rst(rst), .start(start), .insn_hi(insn_hi), .width(width),
        .rs1(rs1), .rs1_vec(rs1_vec), .rs2_vec(rs2_vec), .rd_vec(rd_vec),
        .vl(vl), .pred(pred), .pred_zero(pred_zero),
        .base_raddr(base_raddr), .base_rdata(base_rdata),
        .ofs_raddr(ofs_raddr), .ofs_rdata(ofs_rdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_idx(req_idx), .busy(busy), .done(done), .exc(exc)
    );

    typedef struct packed {
        logic [11:0] hi;
        logic [2:0]  w;
        logic [4:0]  r1;
        logic        v1;
        logic        v2;
        logic        vd;
        logic [4:0]  n;
        logic [15:0] p;
        logic        z;
        logic [4:0]  en;
        logic        ex;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VT [NV] = '{
        // R2 R1: element stride, 8-byte, imm +4
        '{12'h004, 3'd3, 5'd2,  1'b0, 1'b0, 1'b1, 5'd4,  16'hFFFF, 1'b0, 5'd4,  1'b0},
        // R6 R5: imm -512, vector base, 2-byte
        '{12'h200, 3'd1, 5'd3,  1'b1, 1'b0, 1'b1, 5'd3,  16'hFFFF, 1'b0, 5'd3,  1'b0},
        // R3: constant stride, scalar rs2, imm -1
        '{12'h4AF, 3'd2, 5'd1,  1'b0, 1'b0, 1'b1, 5'd3,  16'hFFFF, 1'b0, 5'd3,  1'b0},
        // R3 R1: vector rs2, width[2] set
        '{12'h4C2, 3'd4, 5'd4,  1'b1, 1'b1, 1'b1, 5'd2,  16'hFFFF, 1'b0, 5'd2,  1'b0},
        // R4 R7 R13: indexed, holes in mask, base r31 wraps
        '{12'h8E3, 3'd3, 5'd31, 1'b0, 1'b1, 1'b1, 5'd4,  16'h000A, 1'b0, 5'd2,  1'b0},
        // R4 R6: indexed, imm from bit 30 = -16
        '{12'hD00, 3'd2, 5'd5,  1'b1, 1'b0, 1'b1, 5'd3,  16'hFFFF, 1'b0, 5'd3,  1'b0},
        // R8: scalar destination search
        '{12'h001, 3'd0, 5'd6,  1'b1, 1'b0, 1'b0, 5'd5,  16'h0004, 1'b0, 5'd1,  1'b0},
        // R9: scalar destination with zeroing
        '{12'h001, 3'd0, 5'd6,  1'b1, 1'b0, 1'b0, 5'd5,  16'h0004, 1'b1, 5'd0,  1'b1},
        // R10: zero length
        '{12'h000, 3'd0, 5'd0,  1'b0, 1'b0, 1'b1, 5'd0,  16'hFFFF, 1'b0, 5'd0,  1'b0},
        // R9: zeroing ignored with vector destination
        '{12'h000, 3'd1, 5'd7,  1'b1, 1'b0, 1'b1, 5'd4,  16'h0005, 1'b1, 5'd2,  1'b0},
        // R8: scalar destination, no active element
        '{12'h000, 3'd0, 5'd0,  1'b0, 1'b0, 1'b0, 5'd3,  16'h0000, 1'b0, 5'd0,  1'b0},
        // R2 R13: full length, imm -1
        '{12'h3FF, 3'd3, 5'd9,  1'b1, 1'b0, 1'b1, 5'd16, 16'hFFFF, 1'b0, 5'd16, 1'b0}
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    function automatic logic [63:0] model_addr(input vec_t v, input int i);
        logic [63:0] b, o, imm, esz;
        logic [4:0]  r2;
        esz = 64'd1 << v.w[1:0];
        r2  = v.hi[9:5];
        b   = regval(v.v1 ? 5'(v.r1 + 5'(i)) : v.r1);
        o   = regval(v.v2 ? 5'(r2 + 5'(i)) : r2);
        if (v.hi[11]) begin
            imm = {{59{v.hi[10]}}, v.hi[10], v.hi[3:0]};
            return b + o + imm;
        end else if (v.hi[10]) begin
            imm = {{60{v.hi[3]}}, v.hi[3:0]};
            return b + esz * 64'(i) * o + imm;
        end else begin
            imm = {{54{v.hi[9]}}, v.hi[9:0]};
            return b + esz * 64'(i) + imm;
        end
    endfunction

    task automatic run_vec(input vec_t v, input int stall);
        logic [63:0] ea [16];
        int          ei [16];
        int          m = 0;
        int          k = 0;
        int          guard = 0;
        int          st_left = stall;
        bit          saw_exc = 0;
        string       tag;
        tag = v.hi[11] ? "R4" : (v.hi[10] ? "R3" : "R2");
        for (int i = 0; i < int'(v.n); i++) begin
            if (v.p[i]) begin
                if (!v.vd && v.z) break;
                ea[m] = model_addr(v, i);
                ei[m] = i;
                m++;
                if (!v.vd) break;
            end
        end
        @(negedge clk);
        insn_hi = v.hi; width = v.w; rs1 = v.r1; rs1_vec = v.v1; rs2_vec = v.v2;
        rd_vec = v.vd; vl = v.n; pred = v.p; pred_zero = v.z; req_ready = 1'b1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done && guard < 100) begin
            chk(busy, "R12", "busy during loop", 64'(busy), 64'd1);
            if (exc) saw_exc = 1;
            if (req_valid) begin
                if (k < m) begin
                    chk(req_addr == ea[k], tag, "address (R1 R5 R6 R13)", req_addr, ea[k]);
                    chk(req_idx == 5'(ei[k]), "R7", "element index", 64'(req_idx), 64'(ei[k]));
                end else begin
                    chk(1'b0, "R7", "unexpected request", 64'(req_idx), 64'(m));
                end
                if (st_left > 0) begin
                    req_ready = 1'b0;
                    st_left--;
                end else begin
                    req_ready = 1'b1;
                    k++;
                end
            end else begin
                req_ready = 1'b1;
            end
            @(negedge clk);
            guard++;
        end
        chk(done, "R12", "done reached", 64'(done), 64'd1);
        chk(!busy, "R12", "idle at done", 64'(busy), 64'd0);
        chk(k == int'(v.en), "R7", "request count (R8 R10)", 64'(k), 64'(v.en));
        chk(saw_exc == v.ex, "R9", "exception flag", 64'(saw_exc), 64'(v.ex));
        req_ready = 1'b1;
        @(negedge clk);
        chk(!done, "R12", "done one cycle", 64'(done), 64'd0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected below 20000", cycles);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !done && !req_valid && !exc, "R12", "reset state",
            {60'd0, busy, done, req_valid, exc}, 64'd0);

        for (int n = 0; n < NV; n++) run_vec(VT[n], 0);

        // R11: requests held against a low ready
        run_vec(VT[0], 2);
        run_vec(VT[4], 1);

        // R10: zero length completes in the cycle after start
        @(negedge clk);
        vl = 5'd0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(done && !req_valid && !exc, "R10", "done next cycle",
            {61'd0, done, req_valid, exc}, 64'd4);

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule